// File: doc/BRIEF.md
# Capture-Compare Timer with Flag Status Register

This block is a 16-bit free-running timer. Two input pins are sampled and time-stamped, two programmable compare values are matched against the count, and the block reports wrap-around. Five event flags and a timer-disable bit share one 8-bit status byte. Software reaches everything through a byte-wide register bus: a 4-bit address, read and write strobes, write data, and combinational read data.

Each flag is sticky. It is cleared only by a two-step handshake. First the status byte is read while the flag is 1. Then the low byte of the data register that belongs to that flag is read or written. Each flag has its own small state machine for this handshake, with two states:
- `CLR_IDLE`, the waiting state.
- `CLR_ARMED`, entered after a qualifying status read.

Transitions:
- *arm*: `CLR_IDLE` to `CLR_ARMED`, on a status read while the flag is 1.
- *consume*: `CLR_ARMED` to `CLR_IDLE`, on an access to the flag's low byte.
- *hold*: stay in the current state otherwise.

The counter also has an alias address. Reading the alias gives the same count, but it never clears the overflow flag, so monitoring code can sample time without disturbing that flag.

Top module: `cctimer_status`

## Requirements
- R1: After reset, the counter holds FFFCh, all five flags and the disable bit are 0, the status byte reads 00h and both compare pins are low.
- R2: While enabled, the counter advances by one every 4 clocks. While the disable bit is set, the prescaler and the counter keep their values.
- R3: Register addresses are:
  - 0: status.
  - 1 and 2: counter high and low.
  - 3 and 4: counter alias high and low.
  - 5 and 6: capture 1 high and low.
  - 7 and 8: capture 2 high and low.
  - 9 and 10: compare 1 high and low.
  - 11 and 12: compare 2 high and low.
  
  The status byte is laid out, from bit 7 down, as capture 1, compare 1, overflow, capture 2, compare 2, disable, 0, 0. Only bit 2 is writable, and bits 1:0 always read 0.
- R4: The overflow flag sets when the counter steps from FFFFh to 0000h. A status read followed by an access to address 2 clears it. An access to address 4 leaves it set.
- R5: A compare flag sets when the counter steps to a value equal to its compare register. A status read followed by an access to that compare register's low byte clears it.
- R6: A rising edge on a capture pin passes through a 2-flop synchronizer. It then copies the counter into that channel's capture register and sets its flag. A status read followed by an access to that capture low byte clears the flag.
- R7: Each compare pin toggles on every match of its channel, and is forced low while the disable bit is set.
- R8: A write to any counter or alias byte (addresses 1 to 4) reloads FFFCh and restarts the prescaler. This also works while the timer is disabled.
- R9: With `pwm_mode` high, the capture 1 flag also sets when the counter steps to the compare 2 value.
- R10: If a set event falls in the same cycle as the clearing access, the flag stays 1, and clearing it needs a new status read.
- R11: A status read taken while a flag is 0 does not arm that flag's clear, so a later low-byte access leaves the flag set.
- R12: Reading the high byte of the counter, the alias or a capture register latches the matching low byte. The next low-byte read returns that latched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pwm_mode | input | 1 | Compare 2 match also sets the capture 1 flag |
| cap_pin | input | 2 | Capture inputs, bit 0 is channel 1 |
| cmp_pin | output | 2 | Compare outputs, bit 0 is channel 1 |

## Verification
A flag's set event and its clearing access can land on the same clock edge. The bench provokes this on capture 1:
1. It arms the flag with a status read.
2. It raises the capture pin two cycles ahead, so that the synchronized edge arrives exactly on the edge where the low-byte read is taken.
3. It then checks that the status byte still shows the flag.

A cycle-level reference model, compared on every clock, judges the other coincidences:
- A counter reload against a pending prescaler tick.
- A capture against a latched high-byte read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [3:0] RA_STAT     = 4'd0;
    localparam logic [3:0] RA_CNT_HI   = 4'd1;
    localparam logic [3:0] RA_CNT_LO   = 4'd2;
    localparam logic [3:0] RA_ALT_HI   = 4'd3;
    localparam logic [3:0] RA_ALT_LO   = 4'd4;
    localparam logic [3:0] RA_CAP_BASE = 4'd5;   // hi at base+2*ch, lo at base+2*ch+1
    localparam logic [3:0] RA_CMP_BASE = 4'd9;   // hi at base+2*ch, lo at base+2*ch+1

    // flag vector index, status bit = index + 3
    localparam int FL_CMP2 = 0;
    localparam int FL_CAP2 = 1;
    localparam int FL_OVF  = 2;
    localparam int FL_CMP1 = 3;
    localparam int FL_CAP1 = 4;
    localparam int NFLAG   = 5;

    typedef enum logic {
        CLR_IDLE  = 1'b0,
        CLR_ARMED = 1'b1
    } clr_state_e;

endpackage

// File: rtl/tmr_prescale_counter.sv
module tmr_prescale_counter #(
    parameter int          CNT_W = 16,
    parameter int          DIV   = 4,
    parameter logic [15:0] INIT  = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick    = !hold && (pre_q == PLAST);
    assign cnt_nxt = cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt   <= CNT_W'(INIT);
        end else if (load) begin
            pre_q <= '0;
            cnt   <= CNT_W'(INIT);
        end else if (!hold) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic stat_rd,
    input  logic lo_acc,
    output logic flag
);
    clr_state_e st_q, st_nxt;
    logic       flag_nxt;

    always_comb begin
        st_nxt   = st_q;
        flag_nxt = flag | set_ev;
        unique case (st_q)
            CLR_IDLE: begin
                if (stat_rd && flag) st_nxt = CLR_ARMED;          // arm
            end
            CLR_ARMED: begin
                if (lo_acc) begin                                 // consume
                    st_nxt = CLR_IDLE;
                    if (!set_ev) flag_nxt = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CLR_IDLE;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= flag_nxt;
    end
endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan #(
    parameter int CNT_W = 16,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic [CNT_W-1:0] cnt,
    input  logic             hi_rd,
    input  logic             lo_rd,
    output logic [CNT_W-1:0] cap_val,
    output logic [7:0]       lo_byte,
    output logic             rise
);
    logic [SYNC:0] sync_q;
    logic [7:0]    buf_q;
    logic          hold_q;

    assign rise    = sync_q[SYNC-1] & ~sync_q[SYNC];
    assign lo_byte = hold_q ? buf_q : cap_val[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            cap_val <= '0;
            buf_q   <= '0;
            hold_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-1:0], pin};
            if (rise) cap_val <= cnt;
            if (hi_rd) begin
                buf_q  <= cap_val[7:0];
                hold_q <= 1'b1;
            end else if (lo_rd) begin
                hold_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cctimer_status.sv
module cctimer_status
    import tmr_pkg::*;
#(
    parameter int          PRESC_DIV   = 4,
    parameter logic [15:0] CNT_INIT    = 16'hFFFC,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pwm_mode,
    input  logic [1:0] cap_pin,
    output logic [1:0] cmp_pin
);
    localparam int CNT_W = 16;
    localparam int NCH   = 2;

    logic                        acc;
    logic                        stat_rd;
    logic                        cnt_load;
    logic                        tdis_q;
    logic [CNT_W-1:0]            cnt_q, cnt_nxt;
    logic                        tick;
    logic [NCH-1:0][CNT_W-1:0]   cmp_q;
    logic [NCH-1:0]              match;
    logic [NCH-1:0]              cmp_lvl;
    logic [NCH-1:0][CNT_W-1:0]   cap_val;
    logic [NCH-1:0][7:0]         cap_lo;
    logic [NCH-1:0]              cap_rise;
    logic [7:0]                  cnt_buf_q;
    logic                        cnt_hold_q;
    logic [NFLAG-1:0]            flags, set_v, lo_v;

    assign acc      = bus_rd | bus_wr;
    assign stat_rd  = bus_rd && (bus_addr == RA_STAT);
    assign cnt_load = bus_wr && (bus_addr >= RA_CNT_HI) && (bus_addr <= RA_ALT_LO);

    tmr_prescale_counter #(.CNT_W(CNT_W), .DIV(PRESC_DIV), .INIT(CNT_INIT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(tdis_q), .load(cnt_load),
        .cnt(cnt_q), .cnt_nxt(cnt_nxt), .tick(tick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam logic [3:0] CAP_HI = RA_CAP_BASE + 4'(2 * ch);
        localparam logic [3:0] CAP_LO = CAP_HI + 4'd1;
        localparam logic [3:0] CMP_HI = RA_CMP_BASE + 4'(2 * ch);
        localparam logic [3:0] CMP_LO = CMP_HI + 4'd1;

        tmr_capture_chan #(.CNT_W(CNT_W), .SYNC(SYNC_STAGES)) u_cap (
            .clk(clk), .rst_n(rst_n), .pin(cap_pin[ch]), .cnt(cnt_q),
            .hi_rd(bus_rd && bus_addr == CAP_HI),
            .lo_rd(bus_rd && bus_addr == CAP_LO),
            .cap_val(cap_val[ch]), .lo_byte(cap_lo[ch]), .rise(cap_rise[ch])
        );

        assign match[ch] = tick && (cnt_nxt == cmp_q[ch]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_q[ch]   <= '1;
                cmp_lvl[ch] <= 1'b0;
            end else begin
                if (bus_wr && bus_addr == CMP_HI) cmp_q[ch][15:8] <= bus_wdata;
                if (bus_wr && bus_addr == CMP_LO) cmp_q[ch][7:0]  <= bus_wdata;
                if (match[ch]) cmp_lvl[ch] <= ~cmp_lvl[ch];
            end
        end

        assign cmp_pin[ch] = cmp_lvl[ch] & ~tdis_q;
    end

    assign set_v[FL_CAP1] = cap_rise[0] | (pwm_mode & match[1]);
    assign set_v[FL_CMP1] = match[0];
    assign set_v[FL_OVF]  = tick && (cnt_q == '1);
    assign set_v[FL_CAP2] = cap_rise[1];
    assign set_v[FL_CMP2] = match[1];

    assign lo_v[FL_CAP1] = acc && bus_addr == RA_CAP_BASE + 4'd1;
    assign lo_v[FL_CMP1] = acc && bus_addr == RA_CMP_BASE + 4'd1;
    assign lo_v[FL_OVF]  = acc && bus_addr == RA_CNT_LO;
    assign lo_v[FL_CAP2] = acc && bus_addr == RA_CAP_BASE + 4'd3;
    assign lo_v[FL_CMP2] = acc && bus_addr == RA_CMP_BASE + 4'd3;

    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        tmr_flag_unit u_flag (
            .clk(clk), .rst_n(rst_n), .set_ev(set_v[f]),
            .stat_rd(stat_rd), .lo_acc(lo_v[f]), .flag(flags[f])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdis_q     <= 1'b0;
            cnt_buf_q  <= '0;
            cnt_hold_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == RA_STAT) tdis_q <= bus_wdata[2];
            if (bus_rd && (bus_addr == RA_CNT_HI || bus_addr == RA_ALT_HI)) begin
                cnt_buf_q  <= cnt_q[7:0];
                cnt_hold_q <= 1'b1;
            end else if (bus_rd && (bus_addr == RA_CNT_LO || bus_addr == RA_ALT_LO)) begin
                cnt_hold_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            4'd0:            bus_rdata = {flags, tdis_q, 2'b00};
            4'd1, 4'd3:      bus_rdata = cnt_q[15:8];
            4'd2, 4'd4:      bus_rdata = cnt_hold_q ? cnt_buf_q : cnt_q[7:0];
            4'd5:            bus_rdata = cap_val[0][15:8];
            4'd6:            bus_rdata = cap_lo[0];
            4'd7:            bus_rdata = cap_val[1][15:8];
            4'd8:            bus_rdata = cap_lo[1];
            4'd9:            bus_rdata = cmp_q[0][15:8];
            4'd10:           bus_rdata = cmp_q[0][7:0];
            4'd11:           bus_rdata = cmp_q[1][15:8];
            4'd12:           bus_rdata = cmp_q[1][7:0];
            default:         bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/tmr_status_chk.sv
module tmr_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_rdata,
    input logic [1:0]  cmp_pin,
    input logic        tdis,
    input logic [15:0] cnt,
    input logic [4:0]  flags
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr >= 4'd1) && (bus_addr <= 4'd4);

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'd0) |-> (bus_rdata[1:0] == 2'b00));

    // R7
    cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tdis |-> (cmp_pin == 2'b00));

    // R2
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tdis && !cnt_wr) |=> $stable(cnt));

    // R4
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags[2]) && !$past(cnt_wr)) |-> (cnt == 16'h0000 && $past(cnt) == 16'hFFFF));

    // R4
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[2]) |-> $past((bus_rd || bus_wr) && bus_addr == 4'd2));
endmodule

bind cctimer_status tmr_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .cmp_pin(cmp_pin), .tdis(tdis_q), .cnt(cnt_q), .flags(flags)
);

// File: tb/cctimer_status_test.sv
`timescale 1ns/1ps
module cctimer_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pwm_mode = 1'b0;
    logic [1:0] cap_pin = '0;
    logic [1:0] cmp_pin;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [7:0] rv, v1, v2;

    always #2.5 clk = ~clk;

    cctimer_status uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_mode(pwm_mode),
        .cap_pin(cap_pin), .cmp_pin(cmp_pin)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_pre, m_dis;
    int m_cmp [2];
    int m_cap [2];
    int m_cbuf, m_chold;
    int m_kbuf [2];
    int m_khold [2];
    bit [7:0] m_flg, m_arm;
    bit m_s1 [2];
    bit m_s2 [2];
    bit m_s3 [2];
    bit m_lvl [2];
    bit t_tick, t_acc;
    bit [7:0] t_ev;
    bit t_rise [2];
    int t_nx;

    function automatic int lo_addr(input int b);
        case (b)
            7: return 6;
            6: return 10;
            5: return 2;
            4: return 8;
            default: return 12;
        endcase
    endfunction

    function automatic logic [7:0] pred_rdata(input logic [3:0] a);
        case (a)
            0: return {m_flg[7:3], m_dis[0], 2'b00};
            1, 3: return 8'(m_cnt >> 8);
            2, 4: return m_chold != 0 ? 8'(m_cbuf) : 8'(m_cnt);
            5: return 8'(m_cap[0] >> 8);
            6: return m_khold[0] != 0 ? 8'(m_kbuf[0]) : 8'(m_cap[0]);
            7: return 8'(m_cap[1] >> 8);
            8: return m_khold[1] != 0 ? 8'(m_kbuf[1]) : 8'(m_cap[1]);
            9: return 8'(m_cmp[0] >> 8);
            10: return 8'(m_cmp[0]);
            11: return 8'(m_cmp[1] >> 8);
            12: return 8'(m_cmp[1]);
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 16'hFFFC; m_pre = 0; m_dis = 0;
            m_cmp[0] = 16'hFFFF; m_cmp[1] = 16'hFFFF;
            m_cap[0] = 0; m_cap[1] = 0;
            m_cbuf = 0; m_chold = 0;
            m_flg = '0; m_arm = '0;
            for (int c = 0; c < 2; c++) begin
                m_kbuf[c] = 0; m_khold[c] = 0;
                m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0; m_lvl[c] = 0;
            end
        end else begin
            t_tick = (m_dis == 0) && (m_pre == 3);
            t_nx = (m_cnt + 1) & 16'hFFFF;
            t_acc = bus_rd || bus_wr;
            for (int c = 0; c < 2; c++) t_rise[c] = m_s2[c] && !m_s3[c];
            t_ev = '0;
            t_ev[5] = t_tick && m_cnt == 16'hFFFF;
            t_ev[6] = t_tick && t_nx == m_cmp[0];
            t_ev[3] = t_tick && t_nx == m_cmp[1];
            t_ev[7] = t_rise[0] || (pwm_mode && t_ev[3]);
            t_ev[4] = t_rise[1];
            for (int b = 3; b < 8; b++) begin
                if (m_arm[b]) begin
                    if (t_acc && int'(bus_addr) == lo_addr(b)) begin
                        m_arm[b] = 0;
                        m_flg[b] = t_ev[b];
                    end else m_flg[b] = m_flg[b] | t_ev[b];
                end else begin
                    if (bus_rd && bus_addr == 0 && m_flg[b]) m_arm[b] = 1;
                    m_flg[b] = m_flg[b] | t_ev[b];
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (bus_rd && int'(bus_addr) == 5 + 2 * c) begin
                    m_kbuf[c] = m_cap[c] & 8'hFF; m_khold[c] = 1;
                end else if (bus_rd && int'(bus_addr) == 6 + 2 * c) m_khold[c] = 0;
                if (t_rise[c]) m_cap[c] = m_cnt;
            end
            if (bus_rd && (bus_addr == 1 || bus_addr == 3)) begin
                m_cbuf = m_cnt & 8'hFF; m_chold = 1;
            end else if (bus_rd && (bus_addr == 2 || bus_addr == 4)) m_chold = 0;
            if (t_ev[6]) m_lvl[0] = !m_lvl[0];
            if (t_ev[3]) m_lvl[1] = !m_lvl[1];
            if (bus_wr && bus_addr >= 1 && bus_addr <= 4) begin
                m_cnt = 16'hFFFC; m_pre = 0;
            end else if (m_dis == 0) begin
                if (t_tick) begin m_pre = 0; m_cnt = t_nx; end
                else m_pre = m_pre + 1;
            end
            if (bus_wr && bus_addr == 0) m_dis = int'(bus_wdata[2]);
            for (int c = 0; c < 2; c++) begin
                if (bus_wr && int'(bus_addr) == 9 + 2 * c)  m_cmp[c] = (int'(bus_wdata) << 8) | (m_cmp[c] & 8'hFF);
                if (bus_wr && int'(bus_addr) == 10 + 2 * c) m_cmp[c] = (m_cmp[c] & 16'hFF00) | int'(bus_wdata);
                m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = cap_pin[c];
            end
        end
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            nchk++;
            if (bus_rdata !== pred_rdata(bus_addr)) begin
                nerr++;
                $display("FAIL R3 readback addr=%0d actual=%0h expected=%0h", bus_addr, bus_rdata, pred_rdata(bus_addr));
            end
            nchk++;
            if (cmp_pin !== {(m_dis == 0) && m_lvl[1], (m_dis == 0) && m_lvl[0]}) begin
                nerr++;
                $display("FAIL R7 cmp_pin actual=%0b expected=%0b", cmp_pin,
                         {(m_dis == 0) && m_lvl[1], (m_dis == 0) && m_lvl[0]});
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a);
        bus_addr = a; bus_rd = 1'b1;
        #1 rv = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0);  chk("R1 status", rv, 8'h00);
        chk("R1 cmp_pin", cmp_pin, 2'b00);
        rd(1);  chk("R1 cnt hi", rv, 8'hFF);
        rd(2);  chk("R1 cnt lo", rv, 8'hFC);

        // R2, R12 rate and coherent read
        wr(1, 8'h00);
        idle(8);
        rd(1);  chk("R2 cnt hi", rv, 8'hFF);
        rd(2);  chk("R12 latched lo", rv, 8'hFE);

        // R4, R5 overflow and compare flags (compare regs at FFFFh)
        idle(10);
        rd(0);  chk("R4 R5 flags set", rv, 8'h68);
        rd(4);
        rd(0);  chk("R4 alias keeps overflow", rv, 8'h68);
        rd(2);
        rd(0);  chk("R4 overflow cleared", rv, 8'h48);
        rd(10);
        rd(12);
        rd(0);  chk("R5 compare cleared", rv, 8'h00);

        // R11 no arming while flag is 0
        wr(10, 8'h10);
        wr(9, 8'h00);
        rd(0);
        idle(60);
        rd(10);
        rd(0);  chk("R11 cmp1 kept", int'(rv & 8'h40), 8'h40);
        rd(10);
        rd(0);  chk("R5 cmp1 cleared", int'(rv & 8'h40), 8'h00);

        // R6 capture
        cap_pin[0] = 1'b1; idle(5); cap_pin[0] = 1'b0; idle(3);
        rd(0);  chk("R6 cap1 flag", int'(rv & 8'h80), 8'h80);
        rd(5);  chk("R6 cap1 hi", rv, 8'(m_cap[0] >> 8));
        rd(6);  chk("R6 cap1 lo", rv, 8'(m_cap[0]));
        rd(0);  chk("R6 cap1 cleared", int'(rv & 8'h80), 8'h00);

        // R10 set and clear in the same cycle
        cap_pin[0] = 1'b1; idle(5); cap_pin[0] = 1'b0; idle(3);
        rd(0);
        cap_pin[0] = 1'b1; idle(2);
        rd(6);
        rd(0);  chk("R10 set wins", int'(rv & 8'h80), 8'h80);
        rd(6);
        cap_pin[0] = 1'b0;
        rd(0);  chk("R10 cleared after new read", int'(rv & 8'h80), 8'h00);

        // R9 pwm mode
        pwm_mode = 1'b1;
        wr(12, 8'h04);
        wr(11, 8'h00);
        wr(1, 8'h00);
        idle(40);
        rd(0);  chk("R9 cap1 from cmp2", int'(rv & 8'h88), 8'h88);
        pwm_mode = 1'b0;

        // R7, R2, R8, R3 with the timer disabled
        wr(0, 8'h04);
        chk("R7 pins gated", cmp_pin, 2'b00);
        rd(1); v1 = rv;
        rd(2); v2 = rv;
        idle(20);
        rd(1);  chk("R2 frozen hi", rv, v1);
        rd(2);  chk("R2 frozen lo", rv, v2);
        wr(3, 8'h00);
        rd(1);  chk("R8 reload hi", rv, 8'hFF);
        rd(2);  chk("R8 reload lo", rv, 8'hFC);
        rd(0); v1 = rv;
        wr(0, 8'hFF);
        rd(0);  chk("R3 only bit 2 writable", rv, (v1 | 8'h04) & 8'hFC);
        wr(0, 8'h00);
        idle(30);
        rd(1);  chk("R2 running again", rv, 8'h00);

        done = 1;
        summary();
        $finish;
    end
endmodule